// File: doc/BRIEF.md
# Quadrature Digital Down-Converter

This block moves sampled in-phase/quadrature intermediate-frequency data down to baseband. A 40-bit phase accumulator steps by a programmable frequency word on every clock. Its top 8 bits address a 256-entry, 6-bit cosine table. A second read port of the same table, offset by a quarter cycle, yields the sine. The table values are offset binary centred on 32 and are turned into signed coefficients before a complex mixer rotates each accepted input pair.

The mixer results go to a two-sample summing low-pass stage in each path. This stage is a two-state machine that holds the first sample of a pair and emits the sum when the second arrives. The output rate is therefore half the accepted input rate. A selectable 8-bit window out of the 13-bit filtered word sets the gain. The window is sign-extended to 18 bits for a downstream correlation accumulator.

Software-style writes on a small register port set the frequency word (address 0) and the window select (address 1). The pair machine has two states. `PAIR_EMPTY` goes to `PAIR_HELD` when a mixer result arrives, and stores that result. `PAIR_HELD` goes back to `PAIR_EMPTY` when the next mixer result arrives, and emits the sum. With no mixer result, either state holds. Gaps in the input strobe do not break a pair.

Top module: `qddc_top`

## Requirements
- R1: While `rst` is high at a rising edge, the phase accumulator, frequency word and window select clear to zero, the pair machine returns to `PAIR_EMPTY`, `out_valid` goes low and `out_i`/`out_q` go to zero.
- R2: The phase accumulator adds the frequency word (modulo 2^40) on every clock. A write with `wr_addr`=0 loads `wr_data` as the frequency word at that edge. The new word is first added at the following edge.
- R3: The cosine coefficient for table address p (phase bits 39:32) is round(31·cos(2π(p+0.5)/256)) + 32, stored as 6 bits. The sine coefficient is the entry at address p−64 (mod 256). Each entry is made signed by inverting its top bit, which equals subtracting 32.
- R4: For an input accepted with `in_valid` high, the mixer uses the phase value held before that edge and forms I = in_i·cos − in_q·sin and Q = in_i·sin + in_q·cos. Both inputs are 5-bit two's complement.
- R5: Accepted mixer results are summed in consecutive pairs, regardless of idle cycles between them. Exactly one output is produced per two accepted inputs, and `out_valid` is never high on two consecutive cycles.
- R6: A write with `wr_addr`=1 loads `wr_data[2:0]` as the window select s. The output slice is bits [7+s:s] of the 13-bit filtered word for s from 0 to 5, and select values 6 and 7 act as 5.
- R7: `out_i` and `out_q` carry the 8-bit slice sign-extended to 18 bits by copying the slice's bit 7.
- R8: If the second input of a pair is accepted at edge X, `out_valid` and the outputs for that pair appear after edge X+2 and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = frequency word, 1 = window select |
| wr_data | input | 40 | Write data |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 5 | In-phase sample, two's complement |
| in_q | input | 5 | Quadrature sample, two's complement |
| out_valid | output | 1 | Baseband output strobe |
| out_i | output | 18 | Baseband in-phase, sign-extended |
| out_q | output | 18 | Baseband quadrature, sign-extended |

## Verification
The hardest situation to reach from the ports is a pair that straddles an idle gap or a mixer phase jump. In that case the held half was rotated with a different phase than its partner. Irregular strobes alone do not make this visible, because the output only shows the sum. The random streams therefore use a strobe density near 60 percent, with frequency words whose top byte is random, so that successive accepted samples meet very different table addresses. A reference in the bench tracks the accumulator every clock and pairs samples the same way. Directed runs add all-extreme inputs under every window select, including the values that alias to 5.

// File: rtl/qddc_pkg.sv
package qddc_pkg;
    typedef enum logic {
        PAIR_EMPTY = 1'b0,
        PAIR_HELD  = 1'b1
    } pair_state_e;
endpackage

// File: rtl/qddc_nco.sv
module qddc_nco #(
    parameter int PHASE_W = 40,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step,
    output logic [ADDR_W-1:0]  table_addr
);
    logic [PHASE_W-1:0] phase_acc;

    always_ff @(posedge clk) begin
        if (rst) phase_acc <= '0;
        else     phase_acc <= phase_acc + step;
    end

    assign table_addr = phase_acc[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/qddc_cos_rom.sv
module qddc_cos_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 6
) (
    input  logic [ADDR_W-1:0]        cos_addr,
    output logic signed [DATA_W-1:0] cos_s,
    output logic signed [DATA_W-1:0] sin_s
);
    localparam int DEPTH   = 2 ** ADDR_W;
    localparam int QUARTER = DEPTH / 4;
    localparam int MID     = 2 ** (DATA_W - 1);
    localparam int AMP     = MID - 1;

    function automatic logic [DATA_W-1:0] entry_of(input int idx);
        real ang;
        real val;
        ang = 2.0 * 3.14159265358979 * (real'(idx) + 0.5) / real'(DEPTH);
        val = real'(AMP) * $cos(ang);
        return DATA_W'($rtoi($floor(val + 0.5)) + MID);
    endfunction

    logic [DATA_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam logic [DATA_W-1:0] ENTRY = entry_of(g);
        assign rom[g] = ENTRY;
    end

    logic [ADDR_W-1:0] sin_addr;
    logic [DATA_W-1:0] cos_u;
    logic [DATA_W-1:0] sin_u;

    assign sin_addr = cos_addr - ADDR_W'(QUARTER);
    assign cos_u    = rom[cos_addr];
    assign sin_u    = rom[sin_addr];

    // offset binary to two's complement: flip the top bit
    assign cos_s = {~cos_u[DATA_W-1], cos_u[DATA_W-2:0]};
    assign sin_s = {~sin_u[DATA_W-1], sin_u[DATA_W-2:0]};
endmodule

// File: rtl/qddc_mixer.sv
module qddc_mixer #(
    parameter int IN_W   = 5,
    parameter int COEF_W = 6,
    parameter int MIX_W  = IN_W + COEF_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [IN_W-1:0]   in_i,
    input  logic signed [IN_W-1:0]   in_q,
    input  logic signed [COEF_W-1:0] cos_s,
    input  logic signed [COEF_W-1:0] sin_s,
    output logic                     mix_valid,
    output logic signed [MIX_W-1:0]  mix_i,
    output logic signed [MIX_W-1:0]  mix_q
);
    localparam int PROD_W = IN_W + COEF_W;

    logic signed [PROD_W-1:0] p_ic, p_qs, p_is, p_qc;
    logic signed [MIX_W-1:0]  nxt_i, nxt_q;

    assign p_ic  = in_i * cos_s;
    assign p_qs  = in_q * sin_s;
    assign p_is  = in_i * sin_s;
    assign p_qc  = in_q * cos_s;
    assign nxt_i = {p_ic[PROD_W-1], p_ic} - {p_qs[PROD_W-1], p_qs};
    assign nxt_q = {p_is[PROD_W-1], p_is} + {p_qc[PROD_W-1], p_qc};

    always_ff @(posedge clk) begin
        if (rst) begin
            mix_valid <= 1'b0;
            mix_i     <= '0;
            mix_q     <= '0;
        end else begin
            mix_valid <= in_valid;
            if (in_valid) begin
                mix_i <= nxt_i;
                mix_q <= nxt_q;
            end
        end
    end
endmodule

// File: rtl/qddc_pair_filter.sv
module qddc_pair_filter
    import qddc_pkg::*;
#(
    parameter int MIX_W  = 12,
    parameter int FILT_W = MIX_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mix_valid,
    input  logic signed [MIX_W-1:0]  mix_i,
    input  logic signed [MIX_W-1:0]  mix_q,
    output logic                     filt_valid,
    output logic signed [FILT_W-1:0] filt_i,
    output logic signed [FILT_W-1:0] filt_q
);
    pair_state_e state, state_nxt;
    logic signed [MIX_W-1:0] held_i, held_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PAIR_EMPTY: if (mix_valid) state_nxt = PAIR_HELD;
            PAIR_HELD:  if (mix_valid) state_nxt = PAIR_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PAIR_EMPTY;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_i     <= '0;
            held_q     <= '0;
            filt_valid <= 1'b0;
            filt_i     <= '0;
            filt_q     <= '0;
        end else begin
            filt_valid <= 1'b0;
            if (mix_valid) begin
                unique case (state)
                    PAIR_EMPTY: begin
                        held_i <= mix_i;
                        held_q <= mix_q;
                    end
                    PAIR_HELD: begin
                        filt_i     <= {held_i[MIX_W-1], held_i} + {mix_i[MIX_W-1], mix_i};
                        filt_q     <= {held_q[MIX_W-1], held_q} + {mix_q[MIX_W-1], mix_q};
                        filt_valid <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/qddc_window.sv
module qddc_window #(
    parameter int FILT_W  = 13,
    parameter int SLICE_W = 8,
    parameter int SEL_W   = 3,
    parameter int OUT_W   = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SEL_W-1:0]         sel,
    input  logic                     filt_valid,
    input  logic signed [FILT_W-1:0] filt_i,
    input  logic signed [FILT_W-1:0] filt_q,
    output logic                     out_valid,
    output logic [OUT_W-1:0]         out_i,
    output logic [OUT_W-1:0]         out_q
);
    localparam int MAX_SHIFT = FILT_W - SLICE_W;
    localparam int EXT_W     = OUT_W - SLICE_W;

    logic [SEL_W-1:0]   shift;
    logic [SLICE_W-1:0] slice_i, slice_q;

    always_comb begin
        shift   = (sel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : sel;
        slice_i = filt_i[shift +: SLICE_W];
        slice_q = filt_q[shift +: SLICE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= filt_valid;
            if (filt_valid) begin
                out_i <= {{EXT_W{slice_i[SLICE_W-1]}}, slice_i};
                out_q <= {{EXT_W{slice_q[SLICE_W-1]}}, slice_q};
            end
        end
    end
endmodule

// File: rtl/qddc_top.sv
module qddc_top #(
    parameter int PHASE_W = 40,
    parameter int ADDR_W  = 8,
    parameter int COEF_W  = 6,
    parameter int IN_W    = 5,
    parameter int SEL_W   = 3,
    parameter int SLICE_W = 8,
    parameter int OUT_W   = 18
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic                   wr_addr,
    input  logic [PHASE_W-1:0]     wr_data,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_i,
    output logic [OUT_W-1:0]       out_q
);
    localparam int MIX_W  = IN_W + COEF_W + 1;
    localparam int FILT_W = MIX_W + 1;

    logic [PHASE_W-1:0] freq_word;
    logic [SEL_W-1:0]   win_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            freq_word <= '0;
            win_sel   <= '0;
        end else if (wr_en) begin
            if (wr_addr == 1'b0) freq_word <= wr_data;
            else                 win_sel   <= wr_data[SEL_W-1:0];
        end
    end

    logic [ADDR_W-1:0]        table_addr;
    logic signed [COEF_W-1:0] cos_s, sin_s;
    logic                     mix_valid, filt_valid;
    logic signed [MIX_W-1:0]  mix_i, mix_q;
    logic signed [FILT_W-1:0] filt_i, filt_q;

    qddc_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_nco (
        .clk(clk), .rst(rst), .step(freq_word), .table_addr(table_addr)
    );

    qddc_cos_rom #(.ADDR_W(ADDR_W), .DATA_W(COEF_W)) u_rom (
        .cos_addr(table_addr), .cos_s(cos_s), .sin_s(sin_s)
    );

    qddc_mixer #(.IN_W(IN_W), .COEF_W(COEF_W), .MIX_W(MIX_W)) u_mix (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cos_s(cos_s), .sin_s(sin_s),
        .mix_valid(mix_valid), .mix_i(mix_i), .mix_q(mix_q)
    );

    qddc_pair_filter #(.MIX_W(MIX_W), .FILT_W(FILT_W)) u_filt (
        .clk(clk), .rst(rst), .mix_valid(mix_valid), .mix_i(mix_i), .mix_q(mix_q),
        .filt_valid(filt_valid), .filt_i(filt_i), .filt_q(filt_q)
    );

    qddc_window #(.FILT_W(FILT_W), .SLICE_W(SLICE_W), .SEL_W(SEL_W), .OUT_W(OUT_W)) u_win (
        .clk(clk), .rst(rst), .sel(win_sel), .filt_valid(filt_valid),
        .filt_i(filt_i), .filt_q(filt_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );
endmodule

// File: rtl/qddc_checks.sv
module qddc_checks #(
    parameter int OUT_W   = 18,
    parameter int SLICE_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_i,
    input logic [OUT_W-1:0] out_q
);
    localparam int EXT_W = OUT_W - SLICE_W + 1;

    // R1: outputs are quiet on the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

    // R5: one output per pair, never back to back
    assert_half_rate_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: bits above the slice all copy the slice's top bit
    assert_sign_ext_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (($countones(out_i[OUT_W-1:SLICE_W-1]) == 0 ||
                        $countones(out_i[OUT_W-1:SLICE_W-1]) == EXT_W) &&
                       ($countones(out_q[OUT_W-1:SLICE_W-1]) == 0 ||
                        $countones(out_q[OUT_W-1:SLICE_W-1]) == EXT_W)));

    // R8: an output follows an accepted input three sample points earlier
    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));
endmodule

bind qddc_top qddc_checks #(.OUT_W(OUT_W), .SLICE_W(SLICE_W)) u_checks (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/test_qddc_top.sv
module test_qddc_top;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               wr_en = 1'b0;
    logic               wr_addr = 1'b0;
    logic [39:0]        wr_data = '0;
    logic               in_valid = 1'b0;
    logic signed [4:0]  in_i = '0;
    logic signed [4:0]  in_q = '0;
    logic               out_valid;
    logic [17:0]        out_i, out_q;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1 reset";

    always #(CLK_PERIOD / 2) clk = ~clk;

    qddc_top i_qddc_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    task automatic chk(input bit ok, input string what, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // coefficient from R3: rounded cosine, offset removed
    function automatic int coef(input logic [7:0] a);
        real x;
        x = 31.0 * $cos(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 256.0);
        return $rtoi($floor(x + 0.5));
    endfunction

    // window from R6 and extension from R7
    function automatic logic [17:0] win(input int v, input int s);
        int sh, sl;
        sh = (s > 5) ? 5 : s;
        sl = (v >>> sh) & 255;
        if (sl >= 128) sl = sl - 256;
        return 18'(sl);
    endfunction

    // reference: phase tracking, mixing and pairing
    logic [39:0] m_phase, m_freq;
    int          m_sel, m_hi, m_hq, m_mi, m_mq, m_c, m_s;
    bit          m_held;
    logic [35:0] exp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_phase = '0; m_freq = '0; m_sel = 0; m_held = 1'b0;
        end else begin
            if (in_valid) begin
                m_c  = coef(m_phase[39:32]);
                m_s  = coef(m_phase[39:32] - 8'd64);
                m_mi = int'(in_i) * m_c - int'(in_q) * m_s;
                m_mq = int'(in_i) * m_s + int'(in_q) * m_c;
                if (m_held) begin
                    exp_q.push_back({win(m_hi + m_mi, m_sel), win(m_hq + m_mq, m_sel)});
                    m_held = 1'b0;
                end else begin
                    m_hi = m_mi; m_hq = m_mq; m_held = 1'b1;
                end
            end
            m_phase = m_phase + m_freq;
            if (wr_en) begin
                if (!wr_addr) m_freq = wr_data;
                else          m_sel  = int'(wr_data[2:0]);
            end
        end
    end

    bit          prev_v = 1'b0;
    logic [35:0] e;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                chk(!prev_v, "R5 back-to-back out_valid", 18'(out_valid), 18'(0));
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 output without a pair", out_i, 18'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_i == e[35:18], {tag, " out_i"}, out_i, e[35:18]);
                    chk(out_q == e[17:0],  {tag, " out_q"}, out_q, e[17:0]);
                end
            end
            prev_v = out_valid;
        end
    end

    task automatic wr(input logic a, input logic [39:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic v, input logic [4:0] i, input logic [4:0] q);
        in_valid = v; in_i = i; in_q = q;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (CLK_PERIOD * 10000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 18'(out_valid), 18'h0);
        chk(out_i == '0, "R1 out_i in reset", out_i, 18'h0);
        chk(out_q == '0, "R1 out_q in reset", out_q, 18'h0);
        rst = 1'b0;

        // R8 latency on a single pair, frequency word 0 (R2 hold)
        tag = "R8 R2 R4 first pair";
        send(1'b1, 5'sd1, 5'sd0);
        send(1'b1, 5'sd1, 5'sd0);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8 valid after X", 18'(out_valid), 18'h0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 valid after X+1", 18'(out_valid), 18'h0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8 valid after X+2", 18'(out_valid), 18'h1);
        chk(out_i == 18'd62, "R3 R4 literal out_i (31+31)", out_i, 18'd62);
        idle(4);

        // R2: quarter-turn per clock, every cycle valid
        tag = "R2 R3 R4 quarter-turn step";
        wr(1'b0, 40'h40_0000_0000);
        for (int k = 0; k < 16; k++) send(1'b1, 5'($urandom), 5'($urandom));
        idle(6);

        // R6/R7: every select with extreme inputs
        for (int s = 0; s < 8; s++) begin
            tag = $sformatf("R6 R7 select %0d extreme", s);
            wr(1'b1, 40'(s));
            wr(1'b0, 40'h07_1234_5678);
            for (int k = 0; k < 8; k++)
                send(1'b1, (k % 3 == 0) ? 5'sd15 : -5'sd16, (k % 2 == 0) ? -5'sd16 : 5'sd15);
            idle(6);
        end

        // random streams with gaps: pairs straddle idle cycles (R5)
        for (int r = 0; r < 40; r++) begin
            tag = "R2 R3 R4 R5 R6 R7 random";
            wr(1'b0, {8'($urandom), 32'($urandom)});
            wr(1'b1, 40'($urandom_range(0, 7)));
            for (int k = 0; k < 50; k++)
                send(($urandom_range(0, 9) < 6), 5'($urandom), 5'($urandom));
            idle(6);
        end

        idle(6);
        chk(exp_q.size() == 0, "R5 all pairs emitted", 18'(exp_q.size()), 18'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule